// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Model

This block is a synthesizable, clock-sampled model of a 16-bit-wide asynchronous static RAM, meant to stand in for an external memory chip inside an FPGA image or a simulation environment. The control pins keep the conventions of such a part. There is an active-low select and an active-high select. There is an active-low write strobe and an active-low output enable. Each byte lane has its own active-low enable. Together these pins pick one of four modes: standby, write, read, or read with outputs disabled.

There are no tristate pads. The bidirectional data bus is split into an input bus, an output bus, and one drive-enable flag per byte lane. A pad ring or the testbench combines these into a real bidirectional bus if one is needed.

Writes are committed on the rising edge of the system clock in every cycle in which the write condition holds. Reads are combinational from the addressed word. The depth is 2**ADDR_W words. ADDR_W defaults to a small value so the model elaborates cheaply, and it is set to 19 for the full 512K-word part. The array is not cleared by reset.

Top module: `sram_async_model`

## Requirements
- R1: The array holds 2**ADDR_W words of 16 bits each. A word written at an address is returned by a later read of that address, provided no write to that address intervenes.
- R2: The part is deselected when cs_n is 1, or cs2 is 0, or both lb_n and ub_n are 1. While deselected, drv_lo and drv_hi are 0 and no location changes, even with we_n at 0.
- R3: The part writes when it is selected and we_n is 0, whatever level oe_n has. During a write, drv_lo and drv_hi are both 0.
- R4: In a write, lb_n at 0 stores din[7:0] and ub_n at 0 stores din[15:8]. A lane whose enable is 1 keeps its stored byte.
- R5: The part reads when it is selected, we_n is 1 and oe_n is 0. drv_lo is 1 exactly when lb_n is 0, and drv_hi is 1 exactly when ub_n is 0. A driven lane carries the stored byte of the addressed word.
- R6: A selected read with oe_n at 1 drives neither lane.
- R7: A write commits on every rising clk edge at which the write condition holds, using the addr and din of that cycle. When the condition is held over several edges, the last edge's data remains. Read data follows addr combinationally, so a word is readable in the same cycle that follows its committing edge.
- R8: dout[7:0] is 0 whenever drv_lo is 0, and dout[15:8] is 0 whenever drv_hi is 0.
- R9: While rst_n is 0, no write commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; writes commit on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| addr | input | ADDR_W | Word address |
| cs_n | input | 1 | Active-low chip select |
| cs2 | input | 1 | Active-high chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| lb_n | input | 1 | Active-low enable, low byte (bits 7:0) |
| ub_n | input | 1 | Active-low enable, high byte (bits 15:8) |
| din | input | 16 | Write data |
| dout | output | 16 | Read data; a lane that is not driven reads 0 |
| drv_lo | output | 1 | Low byte lane is being driven |
| drv_hi | output | 1 | High byte lane is being driven |

## Verification
The bench goes after the lane masking first. It writes one lane over a full word and checks that the other byte survives, so a design that stored both lanes would lose it. Each of the three deselect conditions is applied while we_n is 0, and a later read-back shows any write that should not have happened. The same read-back method covers writes attempted during reset.

Drive flags are checked in a write with oe_n at 0, in a read with oe_n at 1, and in a single-lane read. These catch a design that drives the bus during a write, or that lets one lane's enable turn on both lanes. A write held over two edges with its data changed in between shows whether the last edge wins. A read taken straight after the committing edge exposes any hidden read latency. The top address is also used, to catch truncated address decoding.

// File: rtl/sram_async_model.sv
module sram_async_model #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_n,
  input  logic              cs2,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  output logic              drv_lo,
  output logic              drv_hi
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = 2;

  logic             sel;
  logic             wr;
  logic             rd;
  logic [LANES-1:0] en_n;
  logic [LANES-1:0] drv;

  assign en_n   = {ub_n, lb_n};
  assign sel    = !cs_n && cs2 && !(&en_n);
  assign wr     = sel && !we_n;
  assign rd     = sel && we_n && !oe_n;
  assign drv    = {LANES{rd}} & ~en_n;
  assign drv_lo = drv[0];
  assign drv_hi = drv[1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk)
      if (rst_n && wr && !en_n[g]) mem[addr] <= din[g*8 +: 8];

    assign dout[g*8 +: 8] = drv[g] ? mem[addr] : 8'h00;
  end
endmodule

module sram_async_model_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              cs_n,
  input logic              cs2,
  input logic              we_n,
  input logic              oe_n,
  input logic              lb_n,
  input logic              ub_n,
  input logic [15:0]       din,
  input logic [15:0]       dout,
  input logic              drv_lo,
  input logic              drv_hi
);
  assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cs2 || (lb_n && ub_n)) |-> (!drv_lo && !drv_hi));

  assert_write_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!drv_lo && !drv_hi));

  assert_lane_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_lo |-> !lb_n) and (drv_hi |-> !ub_n));

  assert_oe_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!drv_lo && !drv_hi));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_lo |-> dout[7:0] == 8'h00) and (!drv_hi |-> dout[15:8] == 8'h00));

  assert_write_then_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs2 && !we_n && !lb_n) |=>
      ((drv_lo && addr == $past(addr)) ? (dout[7:0] == $past(din[7:0])) : 1'b1));
endmodule

bind sram_async_model sram_async_model_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .cs2(cs2), .we_n(we_n),
  .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .din(din), .dout(dout),
  .drv_lo(drv_lo), .drv_hi(drv_hi)
);

// File: tb/sim_sram_async_model.sv
module sim_sram_async_model;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cs_n = 1'b1, cs2 = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic          lb_n = 1'b1, ub_n = 1'b1;
  logic [15:0]   din = '0;
  logic [15:0]   dout;
  logic          drv_lo, drv_hi;
  int            checks = 0;
  int            failures = 0;

  always #10 clk = ~clk;

  sram_async_model #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .cs2(cs2), .we_n(we_n),
    .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .din(din), .dout(dout),
    .drv_lo(drv_lo), .drv_hi(drv_hi)
  );

  task automatic check(string req, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1; cs2 = 1'b1; we_n = 1'b1; oe_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [15:0] d, logic lb, logic ub);
    @(negedge clk);
    addr = a; din = d; cs_n = 1'b0; cs2 = 1'b1; we_n = 1'b0; oe_n = 1'b1;
    lb_n = lb; ub_n = ub;
    @(negedge clk);
    idle();
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic lb, logic ub,
                        logic [17:0] exp);
    @(negedge clk);
    addr = a; cs_n = 1'b0; cs2 = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    lb_n = lb; ub_n = ub;
    #3;
    check(req, {drv_hi, drv_lo, dout}, exp);
    idle();
  endtask

  task automatic t_reset();
    #3;
    check("R2 reset idle", {drv_hi, drv_lo, dout}, 18'h0);
  endtask

  task automatic t_word();
    wr(10'h011, 16'hA55A, 1'b0, 1'b0);
    rd_chk("R1 word", 10'h011, 1'b0, 1'b0, {2'b11, 16'hA55A});
    wr(10'h3FF, 16'h1234, 1'b0, 1'b0);
    rd_chk("R1 top addr", 10'h3FF, 1'b0, 1'b0, {2'b11, 16'h1234});
    rd_chk("R1 no alias", 10'h011, 1'b0, 1'b0, {2'b11, 16'hA55A});
  endtask

  task automatic t_lanes();
    wr(10'h011, 16'hFFC3, 1'b0, 1'b1);
    rd_chk("R4 low only", 10'h011, 1'b0, 1'b0, {2'b11, 16'hA5C3});
    wr(10'h011, 16'h7E00, 1'b1, 1'b0);
    rd_chk("R4 high only", 10'h011, 1'b0, 1'b0, {2'b11, 16'h7EC3});
    rd_chk("R5 R8 low lane read", 10'h011, 1'b0, 1'b1, {2'b01, 16'h00C3});
    rd_chk("R5 R8 high lane read", 10'h011, 1'b1, 1'b0, {2'b10, 16'h7E00});
  endtask

  task automatic t_oe();
    @(negedge clk);
    addr = 10'h011; cs_n = 1'b0; cs2 = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    lb_n = 1'b0; ub_n = 1'b0;
    #3;
    check("R6 oe high", {drv_hi, drv_lo, dout}, 18'h0);
    idle();
  endtask

  task automatic t_write_oe_low();
    @(negedge clk);
    addr = 10'h022; din = 16'hBEEF; cs_n = 1'b0; cs2 = 1'b1; we_n = 1'b0;
    oe_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
    #3;
    check("R3 no drive in write", {drv_hi, drv_lo, dout}, 18'h0);
    @(negedge clk);
    idle();
    rd_chk("R3 write with oe low", 10'h022, 1'b0, 1'b0, {2'b11, 16'hBEEF});
  endtask

  task automatic t_deselect();
    wr(10'h030, 16'h0F0F, 1'b0, 1'b0);
    @(negedge clk);
    addr = 10'h030; din = 16'hDEAD; cs_n = 1'b1; cs2 = 1'b1; we_n = 1'b0;
    lb_n = 1'b0; ub_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b0; cs2 = 1'b0;
    @(negedge clk);
    cs2 = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
    #3;
    check("R2 both lanes off", {drv_hi, drv_lo}, 2'b00);
    @(negedge clk);
    idle();
    rd_chk("R2 deselected writes ignored", 10'h030, 1'b0, 1'b0,
           {2'b11, 16'h0F0F});
  endtask

  task automatic t_hold_and_latency();
    @(negedge clk);
    addr = 10'h040; din = 16'h1111; cs_n = 1'b0; cs2 = 1'b1; we_n = 1'b0;
    oe_n = 1'b1; lb_n = 1'b0; ub_n = 1'b0;
    @(negedge clk);
    din = 16'h2222;
    @(posedge clk);
    #1;
    we_n = 1'b1; oe_n = 1'b0;
    #2;
    check("R7 last edge wins, zero latency", {drv_hi, drv_lo, dout},
          {2'b11, 16'h2222});
    idle();
    @(negedge clk);
    addr = 10'h050; din = 16'h5050; cs_n = 1'b0; we_n = 1'b0;
    lb_n = 1'b0; ub_n = 1'b0;
    @(negedge clk);
    addr = 10'h051; din = 16'h5151;
    @(negedge clk);
    idle();
    rd_chk("R7 back to back a", 10'h050, 1'b0, 1'b0, {2'b11, 16'h5050});
    rd_chk("R7 back to back b", 10'h051, 1'b0, 1'b0, {2'b11, 16'h5151});
  endtask

  task automatic t_reset_blocks();
    wr(10'h060, 16'h6006, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    wr(10'h060, 16'h9999, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R9 write in reset ignored", 10'h060, 1'b0, 1'b0, {2'b11, 16'h6006});
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_word();
    t_lanes();
    t_oe();
    t_write_oe_low();
    t_deselect();
    t_hold_and_latency();
    t_reset_blocks();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule